// File: doc/BRIEF.md
# Sub-word Load Address and Extension Unit

This unit carries out the data half of a byte or halfword load for a 32-bit processor core. It receives a base register value, a 12-bit unsigned offset, a two-bit load kind and a one-cycle start strobe. It forms the effective address and reads one byte, or two consecutive bytes, through a byte-wide memory read port. It then joins the bytes in little-endian order and widens the value to 32 bits with either zeros or copies of the sign bit.

The finished value appears on the result output for one cycle, together with a destination write-enable and a done pulse. The register file captures it there. The memory port must return read data exactly one cycle after each read strobe. A halfword at any address needs the same number of cycles, because each byte is fetched separately and no alignment is required. The effective address only drives the memory port and is never returned as a result.

Top module: `subword_load_unit`

## Requirements
- R1: The first read strobe is issued in the cycle after start is accepted, at base plus the offset zero-extended to 32 bits, wrapping modulo 2^32.
- R2: For a halfword kind, a second read strobe follows in the very next cycle at the first address plus one, wrapping from FFFFFFFF to 00000000.
- R3: A byte kind issues exactly one read strobe per load.
- R4: Kind 00 (unsigned byte) returns the fetched byte in result bits 7:0 and zeros in bits 31:8.
- R5: Kind 01 (signed byte) returns the fetched byte in bits 7:0 and copies its bit 7 into bits 31:8 (byte 9A gives FFFFFF9A, byte 7A gives 0000007A).
- R6: A halfword kind places the byte from the first address in bits 7:0 and the byte from the second address in bits 15:8.
- R7: Kind 10 (unsigned halfword) clears bits 31:16 (bytes BC then DE give 0000DEBC).
- R8: Kind 11 (signed halfword) copies bit 15 into bits 31:16 (bytes BC then DE give FFFFDEBC).
- R9: A halfword at an odd address is assembled correctly and takes the same latency as an even one (bytes DE then 7E under kind 11 give 00007EDE).
- R10: A start strobe that arrives while a load is in progress is ignored: it causes no extra read and does not alter the load in progress.
- R11: Done and destination write-enable are high together for exactly one cycle with the valid result, 3 cycles after the accepting clock edge for a byte and 4 for a halfword.
- R12: After reset, the read strobe, done and write-enable are low and the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a load when the unit is idle |
| base_i | input | 32 | Base register value |
| imm_i | input | 12 | Unsigned offset |
| kind_i | input | 2 | Load kind: 00 ubyte, 01 sbyte, 10 uhalf, 11 shalf |
| mem_addr_o | output | 32 | Byte address to memory |
| mem_rd_o | output | 1 | Read strobe |
| mem_rdata_i | input | 8 | Read data byte |
| mem_rvalid_i | input | 1 | Read data valid, one cycle after the strobe |
| result_o | output | 32 | Extended load value |
| rd_we_o | output | 1 | Destination register write-enable |
| done_o | output | 1 | Load finished pulse |

## Verification
If the sequencer kept the wrong load kind, the next done pulse would carry wrongly filled upper bits, or it would come one cycle early or late after the wrong number of read strobes. Both show up within four cycles of start. If the captured low byte were corrupted, the halfword result would be wrong only in bits 7:0. If the held address were disturbed by an ignored start, the second strobe would show a wrong address right away, one cycle after the first. Odd and wrapping addresses are exercised so that a carry mistake in the increment shows up on the address port as well as in the data.

// File: rtl/sload_pkg.sv
// Package: shared types for the sub-word load unit.
// Assumes the two-bit load kind encoding below; bit 1 selects halfword, bit 0 selects signed.
package sload_pkg;

    typedef enum logic [1:0] {
        LD_UBYTE = 2'b00,
        LD_SBYTE = 2'b01,
        LD_UHALF = 2'b10,
        LD_SHALF = 2'b11
    } load_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_REQ_LO = 2'b01,
        ST_REQ_HI = 2'b10,
        ST_WAIT   = 2'b11
    } seq_state_e;

    // True when the kind fetches two bytes.
    function automatic logic kind_is_half(input load_kind_e k);
        return k[1];
    endfunction

endpackage

// File: rtl/sload_addr_gen.sv
// Module: effective address adder.
// Adds a zero-extended unsigned offset to the base; the sum wraps at the address width.
module sload_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 12
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic [ADDR_W-1:0] eff_addr_o
);
    localparam int PAD_W = ADDR_W - IMM_W;

    // Zero-extend the offset and add; carry out of the top bit is dropped.
    always_comb begin
        eff_addr_o = base_i + {{PAD_W{1'b0}}, imm_i};
    end

endmodule

// File: rtl/sload_extend.sv
// Module: byte assembly and width extension.
// Joins two bytes little-endian and widens to DATA_W; assumes DATA_W >= 2*BYTE_W.
// For byte kinds the high byte input is not used.
module sload_extend
    import sload_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  load_kind_e        kind_i,
    input  logic [BYTE_W-1:0] byte0_i,
    input  logic [BYTE_W-1:0] byte1_i,
    output logic [DATA_W-1:0] value_o
);
    localparam int HALF_W  = 2 * BYTE_W;
    localparam int BPAD_W  = DATA_W - BYTE_W;
    localparam int HPAD_W  = DATA_W - HALF_W;

    // Select fill pattern according to width and signedness.
    always_comb begin
        case (kind_i)
            LD_UBYTE: value_o = {{BPAD_W{1'b0}}, byte0_i};
            LD_SBYTE: value_o = {{BPAD_W{byte0_i[BYTE_W-1]}}, byte0_i};
            LD_UHALF: value_o = {{HPAD_W{1'b0}}, byte1_i, byte0_i};
            default:  value_o = {{HPAD_W{byte1_i[BYTE_W-1]}}, byte1_i, byte0_i};
        endcase
    end

endmodule

// File: rtl/sload_seq.sv
// Module: byte fetch sequencer.
// Accepts a start when idle, holds address and kind, issues one or two byte reads
// on consecutive cycles (low address first) and flags the cycle the last byte arrives.
// Assumes read data returns exactly one cycle after each strobe.
module sload_seq
    import sload_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        kind_i,
    input  logic [ADDR_W-1:0] eff_addr_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    input  logic [BYTE_W-1:0] mem_rdata_i,
    input  logic              mem_rvalid_i,
    output load_kind_e        kind_q_o,
    output logic [BYTE_W-1:0] byte0_o,
    output logic [BYTE_W-1:0] byte1_o,
    output logic              finish_o
);
    seq_state_e        state;
    logic [ADDR_W-1:0] addr_q;
    load_kind_e        kind_q;
    logic [BYTE_W-1:0] lo_q;

    // State, held address and kind, low-byte capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            kind_q <= LD_UBYTE;
            lo_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        addr_q <= eff_addr_i;
                        kind_q <= load_kind_e'(kind_i);
                        state  <= ST_REQ_LO;
                    end
                end
                ST_REQ_LO: begin
                    state <= kind_is_half(kind_q) ? ST_REQ_HI : ST_WAIT;
                end
                ST_REQ_HI: begin
                    lo_q  <= mem_rdata_i;
                    state <= ST_WAIT;
                end
                default: begin
                    if (mem_rvalid_i) begin
                        state <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    // Memory port drive: strobe in both request states, second byte at address plus one.
    always_comb begin
        mem_rd_o   = (state == ST_REQ_LO) || (state == ST_REQ_HI);
        mem_addr_o = (state == ST_REQ_HI) ? addr_q + ADDR_W'(1) : addr_q;
    end

    // Byte routing to the extender and last-byte flag.
    always_comb begin
        finish_o = (state == ST_WAIT) && mem_rvalid_i;
        byte0_o  = kind_is_half(kind_q) ? lo_q : mem_rdata_i;
        byte1_o  = mem_rdata_i;
        kind_q_o = kind_q;
    end

    assert_first_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REQ_LO) |-> (mem_addr_o == $past(eff_addr_i)));

    assert_second_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REQ_HI) |-> ($past(mem_rd_o) && mem_addr_o == $past(mem_addr_o) + ADDR_W'(1)));

    assert_byte_single_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && $past(mem_rd_o)) |-> kind_is_half(kind_q));

    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && start_i) |=> ($stable(addr_q) && $stable(kind_q)));

endmodule

// File: rtl/subword_load_unit.sv
// Module: sub-word load unit top.
// Wires the address adder, fetch sequencer and extender, and registers the result
// with a one-cycle done and write-enable. Assumes a memory that answers one cycle after a strobe.
module subword_load_unit
    import sload_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 12,
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [1:0]        kind_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    input  logic [BYTE_W-1:0] mem_rdata_i,
    input  logic              mem_rvalid_i,
    output logic [DATA_W-1:0] result_o,
    output logic              rd_we_o,
    output logic              done_o
);
    localparam int HALF_W = 2 * BYTE_W;

    logic [ADDR_W-1:0] eff_addr;
    load_kind_e        kind_q;
    logic [BYTE_W-1:0] byte0;
    logic [BYTE_W-1:0] byte1;
    logic              finish;
    logic [DATA_W-1:0] ext_value;

    sload_addr_gen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_addr (
        .base_i     (base_i),
        .imm_i      (imm_i),
        .eff_addr_o (eff_addr)
    );

    sload_seq #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .kind_i       (kind_i),
        .eff_addr_i   (eff_addr),
        .mem_addr_o   (mem_addr_o),
        .mem_rd_o     (mem_rd_o),
        .mem_rdata_i  (mem_rdata_i),
        .mem_rvalid_i (mem_rvalid_i),
        .kind_q_o     (kind_q),
        .byte0_o      (byte0),
        .byte1_o      (byte1),
        .finish_o     (finish)
    );

    sload_extend #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_ext (
        .kind_i  (kind_q),
        .byte0_i (byte0),
        .byte1_i (byte1),
        .value_o (ext_value)
    );

    // Output register: result with single-cycle done and write-enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            rd_we_o  <= 1'b0;
            done_o   <= 1'b0;
        end else begin
            done_o  <= finish;
            rd_we_o <= finish;
            if (finish) begin
                result_o <= ext_value;
            end
        end
    end

    assert_ubyte_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && kind_q == LD_UBYTE) |-> (result_o[DATA_W-1:BYTE_W] == '0));

    assert_sbyte_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && kind_q == LD_SBYTE) |-> (result_o[DATA_W-1:BYTE_W] == {(DATA_W-BYTE_W){result_o[BYTE_W-1]}}));

    assert_uhalf_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && kind_q == LD_UHALF) |-> (result_o[DATA_W-1:HALF_W] == '0));

    assert_shalf_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && kind_q == LD_SHALF) |-> (result_o[DATA_W-1:HALF_W] == {(DATA_W-HALF_W){result_o[HALF_W-1]}}));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_after_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(mem_rvalid_i) && rd_we_o));

endmodule

// File: tb/subword_load_unit_tb.sv
`timescale 1ns/1ps
module subword_load_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] base_i = '0;
    logic [11:0] imm_i = '0;
    logic [1:0]  kind_i = '0;
    logic [31:0] mem_addr_o;
    logic        mem_rd_o;
    logic [7:0]  mem_rdata_i;
    logic        mem_rvalid_i;
    logic [31:0] result_o;
    logic        rd_we_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0]  mem [16];
    logic [31:0] rd_addr [4];
    int          n_reads = 0;
    int          n_done = 0;

    always #2 clk = ~clk;

    subword_load_unit u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .base_i       (base_i),
        .imm_i        (imm_i),
        .kind_i       (kind_i),
        .mem_addr_o   (mem_addr_o),
        .mem_rd_o     (mem_rd_o),
        .mem_rdata_i  (mem_rdata_i),
        .mem_rvalid_i (mem_rvalid_i),
        .result_o     (result_o),
        .rd_we_o      (rd_we_o),
        .done_o       (done_o)
    );

    // Memory model: answers one cycle after each strobe, logs addresses.
    always @(posedge clk) begin
        mem_rvalid_i <= mem_rd_o;
        mem_rdata_i  <= mem[mem_addr_o[3:0]];
        if (mem_rd_o) begin
            rd_addr[n_reads % 4] <= mem_addr_o;
            n_reads <= n_reads + 1;
        end
        if (done_o) n_done <= n_done + 1;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic do_load(input logic [1:0] k, input logic [31:0] b, input logic [11:0] im,
                           output logic [31:0] res, output int lat, output int first);
        first = n_reads;
        @(negedge clk);
        start_i = 1'b1; kind_i = k; base_i = b; imm_i = im;
        @(negedge clk);
        start_i = 1'b0; lat = 1;
        while (!done_o && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        res = result_o;
        check("R11 we with done", {31'b0, rd_we_o}, {31'b0, done_o});
        @(negedge clk);
        check("R11 done one cycle", {31'b0, done_o}, 32'd0);
    endtask

    task automatic t_reset();
        check("R12 strobe", {31'b0, mem_rd_o}, 32'd0);
        check("R12 done", {31'b0, done_o}, 32'd0);
        check("R12 we", {31'b0, rd_we_o}, 32'd0);
        check("R12 result", result_o, 32'd0);
    endtask

    task automatic t_ubyte();
        logic [31:0] r; int lat; int f;
        do_load(2'b00, 32'h0012D450, 12'd12, r, lat, f);
        check("R4 ubyte 9A", r, 32'h0000009A);
        check("R1 address", rd_addr[f % 4], 32'h0012D45C);
        check("R3 one read", n_reads - f, 1);
        check("R11 byte latency", lat, 3);
    endtask

    task automatic t_sbyte();
        logic [31:0] r; int lat; int f;
        do_load(2'b01, 32'h0012D450, 12'd12, r, lat, f);
        check("R5 sbyte 9A", r, 32'hFFFFFF9A);
        do_load(2'b01, 32'h0012D450, 12'd13, r, lat, f);
        check("R5 sbyte 7A", r, 32'h0000007A);
        check("R3 one read", n_reads - f, 1);
    endtask

    task automatic t_half();
        logic [31:0] r; int lat; int f;
        do_load(2'b10, 32'h0012D450, 12'd14, r, lat, f);
        check("R6 R7 uhalf", r, 32'h0000DEBC);
        check("R2 second addr", rd_addr[(f + 1) % 4], 32'h0012D45F);
        check("R11 half latency", lat, 4);
        do_load(2'b11, 32'h0012D450, 12'd14, r, lat, f);
        check("R8 shalf", r, 32'hFFFFDEBC);
    endtask

    task automatic t_odd_half();
        logic [31:0] r; int lat; int f;
        do_load(2'b11, 32'h0012D450, 12'd15, r, lat, f);
        check("R9 odd shalf", r, 32'h00007EDE);
        check("R9 odd latency", lat, 4);
        check("R9 second addr", rd_addr[(f + 1) % 4], 32'h0012D460);
    endtask

    task automatic t_wrap();
        logic [31:0] r; int lat; int f;
        do_load(2'b00, 32'hFFFFFFF0, 12'hFFF, r, lat, f);
        check("R1 wrap sum", rd_addr[f % 4], 32'h00000FEF);
        check("R1 wrap data", r, {24'h0, mem[4'hF]});
        do_load(2'b10, 32'hFFFFFFFF, 12'h000, r, lat, f);
        check("R2 first", rd_addr[f % 4], 32'hFFFFFFFF);
        check("R2 wrap next", rd_addr[(f + 1) % 4], 32'h00000000);
        check("R6 wrap data", r, {16'h0, mem[4'h0], mem[4'hF]});
    endtask

    task automatic t_busy();
        int f; int d0; int lat;
        f = n_reads;
        d0 = n_done;
        @(negedge clk);
        start_i = 1'b1; kind_i = 2'b10; base_i = 32'h0012D450; imm_i = 12'd14;
        @(negedge clk);
        kind_i = 2'b00; base_i = 32'h00000000; imm_i = 12'd3; lat = 1;
        @(negedge clk); lat++;
        @(negedge clk); lat++;
        start_i = 1'b0;
        while (!done_o && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check("R10 result kept", result_o, 32'h0000DEBC);
        check("R10 latency", lat, 4);
        repeat (5) @(negedge clk);
        check("R10 reads", n_reads - f, 2);
        check("R10 one done", n_done - d0, 1);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 8'h30 + 8'(i);
        mem[4'hC] = 8'h9A; mem[4'hD] = 8'h7A; mem[4'hE] = 8'hBC;
        mem[4'hF] = 8'hDE; mem[4'h0] = 8'h7E;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_ubyte();
        t_sbyte();
        t_half();
        t_odd_half();
        t_wrap();
        t_busy();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule